// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog counter behind a small 16-bit register port. Software programs a coarse 8-bit timeout in half-second units and switches counting on. From then on it must keep the counter from expiring. To do so it writes a two-word key pair to the service register, which reloads the count. If it fails and the count runs out, the block raises a fixed-length reset request. A status register keeps a record of whether a timeout or a software command caused it.

A separate strobe paces the count. It is expected once per half second and comes from outside the block. Three mode inputs (stop, debug, wait) can each hold the count while software has chosen to suspend in that mode. Once set, the enable bit can only be cleared by a reset of the block itself.

Top module: `wdog_keyed`

## Requirements
- R1: Word address 0 is control, 1 is service and 2 is reset status. Address 3 reads 0 and ignores writes. Service reads 0. After reset, control reads 0x0010 and status reads 0x0000.
- R2: Control field positions: bit 0 suspend-in-stop, bit 1 suspend-in-debug, bit 3 timeout mask, bit 7 suspend-in-wait, bits 15:8 timeout value WT. A write updates them. Bits 5 and 6 always read 0.
- R3: Control bit 2 (enable) becomes 1 on a write with that bit set. Later writes with bit 2 clear leave it at 1.
- R4: A control write that first sets enable loads the count with the written WT. Each counted tick then decrements it. A counted tick that finds the count at zero is an expiry, and it reloads the count with WT. Expiry therefore falls on the (WT+1)th counted tick.
- R5: A service write of 0x5555 arms the key. If the next service write is 0xAAAA, it reloads the count with WT and disarms. Any other service write disarms without a reload. Writes to other addresses do not change the armed state.
- R6: A tick is not counted when enable is 0. It is also not counted when the stop, debug or wait input is high and its suspend bit is set.
- R7: If the timeout mask bit is 0, an expiry raises rst_req_o for exactly 4 cycles, starting the cycle after, and sets status bit 1. If the mask bit is 1, an expiry only reloads the count.
- R8: A control write with bit 4 at 0 raises rst_req_o for 4 cycles and sets status bit 0. Bit 4 always reads 1.
- R9: Any write to the status register clears both cause bits. A cause raised in the same cycle wins. A new trigger while rst_req_o is high restarts the 4-cycle window.
- R10: If a load (enable set or key reload) falls in the same cycle as a tick, the load wins and the tick is not counted.
- R11: Writing control 0x0004 and then the key pair arms WT=0. The next counted tick expires, and rst_req_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | Half-second count strobe, one cycle wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 16 | Write data |
| stop_i | input | 1 | Low-power stop mode active |
| dbg_i | input | 1 | Debug mode active |
| wait_i | input | 1 | Wait mode active |
| rst_req_o | output | 1 | System reset request pulse |
| rdata_o | output | 16 | Read data for addr_i, combinational |

## Verification
The bench uses the default parameters: an 8-bit WT field and a 4-cycle reset pulse. It drives tick_i every cycle or every few cycles instead of every half second. As a result, the full 256-tick timeout at WT=255, the minimum one-tick timeout, and several expiries in a row all fit in a short run. The pulse length stays short enough to test retriggering inside the window, and to test a status clear in the same cycle as a new cause.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_SVC  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

  localparam int B_SUSP_STOP = 0;
  localparam int B_SUSP_DBG  = 1;
  localparam int B_EN        = 2;
  localparam int B_TMO_MASK  = 3;
  localparam int B_SWR       = 4;
  localparam int B_SUSP_WAIT = 7;
  localparam int B_WT_LO     = 8;
  localparam int unsigned TO_W = REG_W - B_WT_LO;

  localparam int S_SW  = 0;
  localparam int S_TMO = 1;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             en_o,
  output logic             tmo_mask_o,
  output logic [2:0]       susp_o,      // {wait, dbg, stop}
  output logic [TO_W-1:0]  wt_o,
  output logic             load_o,
  output logic [TO_W-1:0]  load_val_o,
  output logic             sw_trig_o,
  output logic [REG_W-1:0] rdata_o
);
  logic            en_q, mask_q;
  logic [2:0]      susp_q;
  logic [TO_W-1:0] wt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      susp_q <= '0;
      wt_q   <= '0;
    end else if (we_i) begin
      en_q   <= en_q | wdata_i[B_EN];
      mask_q <= wdata_i[B_TMO_MASK];
      susp_q <= {wdata_i[B_SUSP_WAIT], wdata_i[B_SUSP_DBG], wdata_i[B_SUSP_STOP]};
      wt_q   <= wdata_i[REG_W-1 -: TO_W];
    end
  end

  assign load_o     = we_i & wdata_i[B_EN] & ~en_q;
  assign load_val_o = wdata_i[REG_W-1 -: TO_W];
  assign sw_trig_o  = we_i & ~wdata_i[B_SWR];
  assign en_o       = en_q;
  assign tmo_mask_o = mask_q;
  assign susp_o     = susp_q;
  assign wt_o       = wt_q;

  always_comb begin
    rdata_o                  = '0;
    rdata_o[B_SUSP_STOP]     = susp_q[0];
    rdata_o[B_SUSP_DBG]      = susp_q[1];
    rdata_o[B_EN]            = en_q;
    rdata_o[B_TMO_MASK]      = mask_q;
    rdata_o[B_SWR]           = 1'b1;
    rdata_o[B_SUSP_WAIT]     = susp_q[2];
    rdata_o[REG_W-1 -: TO_W] = wt_q;
  end

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q); // R3
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             reload_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (we_i) armed_q <= (wdata_i == KEY_ARM);
  end

  assign reload_o = we_i & armed_q & (wdata_i == KEY_FIRE);

  AST_ARM_ON_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(we_i && wdata_i == KEY_ARM)); // R5
  AST_ARM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(armed_q)); // R5
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
  parameter int unsigned TO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic [TO_W-1:0] ld_val_i,
  input  logic [TO_W-1:0] wt_i,
  input  logic            tick_i,
  input  logic            run_i,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q;
  logic            step;

  assign step     = tick_i & run_i & ~ld_i;
  assign expire_o = step & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (ld_i)     cnt_q <= ld_val_i;
    else if (expire_o) cnt_q <= wt_i;
    else if (step)     cnt_q <= cnt_q - TO_W'(1);
  end

  AST_TICK_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_i && !ld_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - TO_W'(1)); // R4
  AST_SUSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !run_i) |=> $stable(cnt_q)); // R6
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_q == $past(ld_val_i)); // R10
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic req_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (trig_i)        cnt_q <= CW'(LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign req_o = (cnt_q != '0);

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> req_o); // R7
  AST_PULSE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && !req_o) |=> !req_o); // R8
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              stop_i,
  input  logic              dbg_i,
  input  logic              wait_i,
  output logic              rst_req_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic            we_ctl, we_svc, we_stat;
  logic            en, tmo_mask, en_load, sw_trig, reload, expire, fire, trig, run;
  logic [2:0]      susp;
  logic [TO_W-1:0] wt, en_val, ld_val;
  logic [REG_W-1:0] ctl_rdata;
  logic [1:0]      stat_q;

  assign we_ctl  = we_i & (addr_i == A_CTL);
  assign we_svc  = we_i & (addr_i == A_SVC);
  assign we_stat = we_i & (addr_i == A_STAT);

  wdog_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .we_i(we_ctl), .wdata_i,
    .en_o(en), .tmo_mask_o(tmo_mask), .susp_o(susp), .wt_o(wt),
    .load_o(en_load), .load_val_o(en_val), .sw_trig_o(sw_trig), .rdata_o(ctl_rdata)
  );

  wdog_key_seq u_key (
    .clk_i, .rst_ni, .we_i(we_svc), .wdata_i, .reload_o(reload)
  );

  assign run    = en & ~|(susp & {wait_i, dbg_i, stop_i});
  assign ld_val = en_load ? en_val : wt;

  wdog_down_cnt #(.TO_W(TO_W)) u_cnt (
    .clk_i, .rst_ni, .ld_i(en_load | reload), .ld_val_i(ld_val), .wt_i(wt),
    .tick_i, .run_i(run), .expire_o(expire)
  );

  assign fire = expire & ~tmo_mask;
  assign trig = fire | sw_trig;

  wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i, .rst_ni, .trig_i(trig), .req_o(rst_req_o)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else begin
      stat_q[S_SW]  <= sw_trig | (stat_q[S_SW]  & ~we_stat);
      stat_q[S_TMO] <= fire    | (stat_q[S_TMO] & ~we_stat);
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTL:   rdata_o = ctl_rdata;
      A_STAT:  rdata_o = {{(REG_W-2){1'b0}}, stat_q};
      default: rdata_o = '0;
    endcase
  end

  AST_TMO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> stat_q[S_TMO]); // R7
  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && tmo_mask) |=> ($stable(stat_q[S_TMO]) || !stat_q[S_TMO])); // R7
  AST_SW_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_trig |=> stat_q[S_SW]); // R8
  AST_CAUSE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_stat && !trig) |=> stat_q == 2'b00); // R9
endmodule

// File: tb/wdog_keyed_tb_top.sv
`timescale 1ns/1ps
module wdog_keyed_tb_top;
  localparam int PULSE = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = 16'h0;
  logic        stop_i = 1'b0, dbg_i = 1'b0, wait_i = 1'b0;
  logic        rst_req_o;
  logic [15:0] rdata_o;

  always #2 clk_i = ~clk_i;

  wdog_keyed #(.PULSE_LEN(PULSE)) dut_i (.*);

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";

  bit m_en, m_mask, m_sstop, m_sdbg, m_swait, m_armed, m_sw, m_tmo;
  int m_wt, m_cnt, m_pulse;

  task automatic model_reset();
    m_en = 0; m_mask = 0; m_sstop = 0; m_sdbg = 0; m_swait = 0; m_armed = 0;
    m_sw = 0; m_tmo = 0; m_wt = 0; m_cnt = 0; m_pulse = 0;
  endtask

  task automatic model_step();
    bit ctlw, svcw, stw, susp, swt, ld, fire;
    int lv;
    ctlw = we_i && addr_i == 2'd0;
    svcw = we_i && addr_i == 2'd1;
    stw  = we_i && addr_i == 2'd2;
    susp = (stop_i && m_sstop) || (dbg_i && m_sdbg) || (wait_i && m_swait);
    swt  = ctlw && !wdata_i[4];
    ld = 0; lv = 0; fire = 0;
    if (ctlw && wdata_i[2] && !m_en) begin ld = 1; lv = int'(wdata_i[15:8]); end
    if (svcw && m_armed && wdata_i == 16'hAAAA) begin ld = 1; lv = m_wt; end
    if (ld) m_cnt = lv;
    else if (tick_i && m_en && !susp) begin
      if (m_cnt == 0) begin fire = !m_mask; m_cnt = m_wt; end
      else m_cnt = m_cnt - 1;
    end
    if (svcw) m_armed = (wdata_i == 16'h5555);
    if (ctlw) begin
      m_en = m_en | wdata_i[2]; m_mask = wdata_i[3];
      m_sstop = wdata_i[0]; m_sdbg = wdata_i[1]; m_swait = wdata_i[7];
      m_wt = int'(wdata_i[15:8]);
    end
    if (swt || fire) m_pulse = PULSE;
    else if (m_pulse > 0) m_pulse = m_pulse - 1;
    m_sw  = swt  || (m_sw  && !stw);
    m_tmo = fire || (m_tmo && !stw);
  endtask

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    logic [15:0] r;
    r = '0;
    if (a == 2'd0) begin
      r[0] = m_sstop; r[1] = m_sdbg; r[2] = m_en; r[3] = m_mask; r[4] = 1'b1;
      r[7] = m_swait; r[15:8] = m_wt[7:0];
    end else if (a == 2'd2) begin
      r[0] = m_sw; r[1] = m_tmo;
    end
    return r;
  endfunction

  task automatic compare();
    n_tests++;
    if (rst_req_o !== (m_pulse != 0)) begin
      n_fail++;
      $display("FAIL %s rst_req_o act=%0b exp=%0b t=%0t", cur_req, rst_req_o, m_pulse != 0, $time);
    end
    n_tests++;
    if (rdata_o !== exp_rd(addr_i)) begin
      n_fail++;
      $display("FAIL %s rdata[a=%0d] act=%h exp=%h t=%0t", cur_req, addr_i, rdata_o, exp_rd(addr_i), $time);
    end
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic cyc(input bit we, input logic [1:0] a, input logic [15:0] d, input bit tk);
    we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    we_i = 1'b0; tick_i = 1'b0;
    compare();
  endtask

  task automatic run_ticks(input int n, input int every, input logic [1:0] a);
    for (int i = 0; i < n; i++) cyc(0, a, 16'h0, (i % every) == every - 1);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; we_i = 0; tick_i = 0;
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare();
  endtask

  task automatic key_pair();
    cyc(1, 2'd1, 16'h5555, 0);
    cyc(1, 2'd1, 16'hAAAA, 0);
  endtask

  task automatic run_all();
    // R1: reset state and map
    cur_req = "R1";
    do_reset();
    for (int a = 0; a < 4; a++) cyc(0, 2'(a), 16'h0, 0);
    cyc(1, 2'd3, 16'hFFFF, 0);
    for (int a = 0; a < 4; a++) cyc(0, 2'(a), 16'h0, 0);
    // R2: fields, reserved bits, enable left off
    cur_req = "R2";
    cyc(1, 2'd0, 16'h3CFB, 0);
    run_ticks(6, 2, 2'd0);
    // R8: software reset, status, retrigger in window
    cur_req = "R8";
    cyc(1, 2'd0, 16'h3C8B, 0);
    run_ticks(2, 9, 2'd2);
    cyc(1, 2'd0, 16'h3C8B, 0);
    run_ticks(6, 9, 2'd2);
    // R9: clear; clear with coincident cause
    cur_req = "R9";
    cyc(1, 2'd2, 16'hFFFF, 0);
    cyc(0, 2'd2, 16'h0, 0);
    cyc(1, 2'd0, 16'h3C8B, 0);
    cyc(1, 2'd2, 16'h0, 0);
    run_ticks(6, 9, 2'd2);
    // R4: enable, count WT=3, repeated expiries
    cur_req = "R4";
    cyc(1, 2'd0, 16'h0314, 0);
    run_ticks(24, 2, 2'd2);
    cyc(1, 2'd2, 16'h0, 0);
    // R3: enable cannot be cleared
    cur_req = "R3";
    cyc(1, 2'd0, 16'h0310, 0);
    cyc(0, 2'd0, 16'h0, 0);
    // R5: good pair, broken pair, pair across other access
    cur_req = "R5";
    for (int k = 0; k < 6; k++) begin
      run_ticks(5, 2, 2'd0);
      key_pair();
    end
    cyc(1, 2'd1, 16'h5555, 0);
    cyc(1, 2'd1, 16'h1234, 0);
    cyc(1, 2'd1, 16'hAAAA, 0);
    run_ticks(6, 2, 2'd2);
    cyc(1, 2'd2, 16'h0, 0);
    cyc(1, 2'd1, 16'h5555, 0);
    cyc(1, 2'd2, 16'h0, 0);
    cyc(1, 2'd0, 16'h0314, 0);
    cyc(1, 2'd1, 16'hAAAA, 0);
    run_ticks(10, 2, 2'd2);
    // R10: load beats tick
    cur_req = "R10";
    cyc(1, 2'd1, 16'h5555, 0);
    cyc(1, 2'd1, 16'hAAAA, 1);
    run_ticks(10, 2, 2'd2);
    // R6: suspends
    cur_req = "R6";
    cyc(1, 2'd0, 16'h0297, 0);
    key_pair();
    stop_i = 1; run_ticks(12, 2, 2'd2);
    stop_i = 0; wait_i = 1; run_ticks(12, 2, 2'd2);
    wait_i = 0; dbg_i = 1; run_ticks(12, 2, 2'd2);
    dbg_i = 0; run_ticks(12, 2, 2'd2);
    // R7: mask bit suppresses request and cause
    cur_req = "R7";
    cyc(1, 2'd2, 16'h0, 0);
    cyc(1, 2'd0, 16'h021C, 0);
    key_pair();
    run_ticks(16, 2, 2'd2);
    cyc(1, 2'd0, 16'hFF14, 0);
    key_pair();
    run_ticks(262, 1, 2'd2);
    // R11: minimum timeout from fresh reset
    cur_req = "R11";
    do_reset();
    cyc(1, 2'd0, 16'h0004, 0);
    run_ticks(6, 9, 2'd2);
    cyc(1, 2'd2, 16'h0, 0);
    key_pair();
    run_ticks(8, 4, 2'd2);
  endtask

  initial begin
    bit hung;
    hung = 0;
    fork
      run_all();
      begin repeat (150000) @(posedge clk_i); hung = 1; end
    join_any
    disable fork;
    if (hung) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule